// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block derives the serial clock for a synchronous serial port from a fast peripheral clock. The division happens in two programmable stages. The first is a prescaler with an even-only divisor. The second is a post-divider that counts (1 + rate) prescaler steps. The serial bit period is therefore `prescale * (1 + rate)` peripheral clock cycles.

The generator raises `edge_tick_o` for one cycle at every serial clock edge, which is twice per bit. Each bit therefore gets one launch edge and one capture edge. `sclk_o` toggles in the same cycle that `edge_tick_o` is high. Outside a transfer, `sclk_o` rests at the level set by the polarity input.

Configuration is captured only while the port is disabled. Once `en_i` is high, the captured values stay frozen until the port is disabled again.

Top module: `bit_rate_gen`

## Requirements
- R1: While `rst_ni` is low, `edge_tick_o` is 0 and `sclk_o` is 0.
- R2: After any clock edge at which `en_i` is low, `edge_tick_o` is 0 and `sclk_o` equals the `cpol_i` value sampled at that edge.
- R3: With normalised prescale P and rate value N, counting from the first rising edge at which `en_i` is high as cycle 0, `edge_tick_o` is high exactly in cycles k*(P/2)*(1+N) - 1 for k = 1, 2, ... and low in all other enabled cycles.
- R4: `sclk_o` inverts in every cycle in which `edge_tick_o` is high, and holds its level in every other enabled cycle. It starts from the idle level, so two ticks make one full serial clock period.
- R5: Bit 0 of `prescale_i` is ignored. An odd prescale value behaves exactly like the even value one below it.
- R6: A prescale value whose upper seven bits are zero (0 or 1) is treated as 2, so the divider never stalls.
- R7: Changes on `prescale_i`, `rate_i` and `cpol_i` while `en_i` is high have no effect until the port has been disabled again.
- R8: The extreme setting, prescale 254 with rate 255, produces a tick every 32512 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable; low holds the counters cleared and loads configuration |
| prescale_i | input | 8 | Prescale divisor, even, 2..254 (bit 0 ignored, 0 treated as 2) |
| rate_i | input | 8 | Post-divide value N; the divider counts 1+N prescaler steps |
| cpol_i | input | 1 | Idle level of the serial clock |
| edge_tick_o | output | 1 | One-cycle pulse at each serial clock edge |
| sclk_o | output | 1 | Serial clock output |

## Verification
The assertions check, on every cycle, the following properties:
- a disabled edge forces the tick low and the clock to the sampled idle level;
- the serial clock inverts exactly when a tick is shown and is otherwise stable;
- the captured configuration does not move while the port stays enabled.

Only the bench scenarios can show that ticks land in the right cycles for a given prescale and rate. The same holds for the odd and zero prescale normalisation, for mid-transfer configuration writes being ignored, and for the extreme division setting.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int unsigned PRE_W_DEF  = 8;
  localparam int unsigned RATE_W_DEF = 8;
endpackage

// File: rtl/brg_cfg_latch.sv
module brg_cfg_latch #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned RATE_W = 8,
  localparam int unsigned HALF_W = PRE_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [HALF_W-1:0] half_o,
  output logic [RATE_W-1:0] rate_o
);
  logic [HALF_W-1:0] half_nxt;
  logic [HALF_W-1:0] half_q;
  logic [RATE_W-1:0] rate_q;

  // bit 0 dropped: half = P/2; zero maps to half of 2
  always_comb begin
    half_nxt = prescale_i[PRE_W-1:1];
    if (half_nxt == '0) half_nxt = HALF_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= HALF_W'(1);
      rate_q <= '0;
    end else if (!en_i) begin
      half_q <= half_nxt;
      rate_q <= rate_i;
    end
  end

  assign half_o = half_q;
  assign rate_o = rate_q;
endmodule

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             step_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             wrap;

  assign last   = half_i - CNT_W'(1);
  assign wrap   = (cnt_q == last);
  assign step_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/brg_postdiv.sv
module brg_postdiv #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] rate_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == rate_i);
  assign tick_o = en_i && step_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/brg_sclk_gen.sv
module brg_sclk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cpol_i,
  input  logic tick_i,
  output logic tick_o,
  output logic sclk_o
);
  logic tick_q;
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      tick_q <= 1'b0;
      sclk_q <= cpol_i;  // idle level captured while disabled
    end else begin
      tick_q <= tick_i;
      sclk_q <= sclk_q ^ tick_i;
    end
  end

  assign tick_o = tick_q;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/bit_rate_gen.sv
module bit_rate_gen #(
  parameter int unsigned PRE_W  = brg_pkg::PRE_W_DEF,
  parameter int unsigned RATE_W = brg_pkg::RATE_W_DEF,
  localparam int unsigned HALF_W = PRE_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              cpol_i,
  output logic              edge_tick_o,
  output logic              sclk_o
);
  logic [HALF_W-1:0] half_w;
  logic [RATE_W-1:0] rate_w;
  logic              step_w;
  logic              tick_w;

  brg_cfg_latch #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .prescale_i (prescale_i),
    .rate_i     (rate_i),
    .half_o     (half_w),
    .rate_o     (rate_w)
  );

  brg_prescaler #(.CNT_W(HALF_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .half_i (half_w),
    .step_o (step_w)
  );

  brg_postdiv #(.CNT_W(RATE_W)) u_post (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .step_i (step_w),
    .rate_i (rate_w),
    .tick_o (tick_w)
  );

  brg_sclk_gen u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cpol_i (cpol_i),
    .tick_i (tick_w),
    .tick_o (edge_tick_o),
    .sclk_o (sclk_o)
  );
endmodule

// File: rtl/brg_chk.sv
module brg_chk #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned RATE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              cpol_i,
  input logic              edge_tick_o,
  input logic              sclk_o,
  input logic [PRE_W-2:0]  half_q,
  input logic [RATE_W-1:0] rate_q
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !edge_tick_o);

  // R2
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o == $past(cpol_i)));

  // R4
  sclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_tick_o |-> (sclk_o != $past(sclk_o)));

  // R4
  sclk_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !edge_tick_o) |-> $stable(sclk_o));

  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> ($stable(half_q) && $stable(rate_q)));
endmodule

bind bit_rate_gen brg_chk #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .cpol_i      (cpol_i),
  .edge_tick_o (edge_tick_o),
  .sclk_o      (sclk_o),
  .half_q      (half_w),
  .rate_q      (rate_w)
);

// File: tb/sim_bit_rate_gen.sv
module sim_bit_rate_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] prescale_i = 8'd0;
  logic [7:0] rate_i = 8'd0;
  logic       cpol_i = 1'b1;
  logic       edge_tick_o;
  logic       sclk_o;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  string cur_req = "R2";
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bit_rate_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .prescale_i(prescale_i),
    .rate_i(rate_i), .cpol_i(cpol_i), .edge_tick_o(edge_tick_o), .sclk_o(sclk_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected tick cycles, models sclk independently
  initial begin
    int  cyc;
    bit  exp_sclk;
    bit  en_e;
    bit  pol_e;
    bit  exp_tick;
    cyc = 0;
    exp_sclk = 1'b0;
    forever begin
      @(posedge clk_i);
      en_e  = en_i;
      pol_e = cpol_i;
      #2;
      if (rst_ni) begin
        if (!en_e) begin
          cyc = 0;
          exp_sclk = pol_e;
          chk("R2", "idle tick", int'(edge_tick_o), 0);
          chk("R2", "idle sclk", int'(sclk_o), int'(exp_sclk));
        end else begin
          exp_tick = (exp_q.size() > 0) && (exp_q[0] == cyc);
          if (exp_tick) begin
            void'(exp_q.pop_front());
            exp_sclk = ~exp_sclk;
          end
          chk(cur_req, $sformatf("tick@%0d", cyc), int'(edge_tick_o), int'(exp_tick));
          chk("R4", $sformatf("sclk@%0d", cyc), int'(sclk_o), int'(exp_sclk));
          cyc++;
        end
      end
    end
  end

  task automatic run_case(input string req, input int pre, input int rt, input bit pol,
                          input int win, input bit poke);
    int h;
    int per;
    @(negedge clk_i);
    en_i = 1'b0; prescale_i = 8'(pre); rate_i = 8'(rt); cpol_i = pol;
    repeat (3) @(negedge clk_i);
    h = ((pre >> 1) == 0) ? 1 : (pre >> 1);
    per = h * (rt + 1);
    for (int k = per - 1; k < win; k += per) exp_q.push_back(k);
    cur_req = req;
    en_i = 1'b1;
    for (int i = 0; i < win; i++) begin
      @(negedge clk_i);
      if (poke && i == 4) begin
        prescale_i = 8'd2; rate_i = 8'd0; cpol_i = ~pol;  // R7: must be ignored
      end
    end
    en_i = 1'b0;
    @(negedge clk_i);
    chk(req, "leftover expected ticks", exp_q.size(), 0);
    exp_q.delete();
    cur_req = "R2";
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: outputs held at zero during reset even with polarity 1
    chk("R1", "reset tick", int'(edge_tick_o), 0);
    chk("R1", "reset sclk", int'(sclk_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    run_case("R3", 2, 0, 1'b0, 10, 1'b0);      // tick every cycle
    run_case("R3", 4, 2, 1'b1, 40, 1'b0);      // period 6
    run_case("R3", 6, 4, 1'b0, 50, 1'b0);      // period 15
    run_case("R5", 5, 1, 1'b1, 30, 1'b0);      // odd 5 acts as 4: period 4
    run_case("R6", 0, 3, 1'b0, 30, 1'b0);      // 0 acts as 2: period 4
    run_case("R6", 1, 0, 1'b1, 12, 1'b0);      // 1 acts as 2: period 1
    run_case("R7", 10, 0, 1'b0, 40, 1'b1);     // period 5 despite writes
    run_case("R8", 254, 255, 1'b1, 65030, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule